// File: doc/BRIEF.md
# Core Clock-Stop Power Controller

This block decides when a processor core's internal clock may run. Two active-low request pins come in from outside the clock domain: a stop-clock request and a sleep request. Each passes through a synchronizer of its own. A small state machine then moves among three power levels:

- **Running.** The core clock is enabled.
- **Stop-grant.** The core clock is gated, but bus snooping is still allowed.
- **Sleep.** The core clock is gated and snooping is withdrawn. Only the PLL stays enabled.

Sleep is the deeper level and can be reached only from stop-grant. Leaving sleep always passes back through stop-grant.

A stop request does not gate the clock at once. The controller first waits for the core to report that it is idle. On entry to stop-grant it gives a one-cycle acknowledge. The external clock-gating cell and the PLL consume the enables driven here. The bus clock has no path through this block, so it is never affected.

Top module: `pcs_clkstop_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `core_clk_en`=1, `pll_en`=1, `snoop_en`=1 and `stop_ack`=0.
- R2: Both request pins are active-low and pass through two synchronizer flops. A pin change driven between clock edges reaches the outputs on the third rising edge after it, and not before.
- R3: With the stop request asserted and `core_idle`=0, `core_clk_en` stays 1. On the first edge at which `core_idle`=1 is seen with the request still asserted, `core_clk_en` falls to 0.
- R4: `stop_ack` is a single-cycle pulse, raised on the edge at which stop-grant is entered from running or from the idle wait. Returning from sleep to stop-grant raises no pulse.
- R5: In stop-grant, `core_clk_en`=0 and `snoop_en`=1.
- R6: Releasing the stop request, in stop-grant or during the idle wait, returns the block to running with `core_clk_en`=1 and `snoop_en`=1.
- R7: A sleep request in stop-grant leads to sleep, where `core_clk_en`=0 and `snoop_en`=0.
- R8: A sleep request while running, with no stop request, has no effect: `core_clk_en` and `snoop_en` stay 1.
- R9: Releasing the sleep request in sleep leads to stop-grant (`snoop_en`=1, `core_clk_en`=0) if the stop request is still asserted. If the stop request is released as well, the block passes through stop-grant and only then reaches running.
- R10: `pll_en` is 1 in every state, including sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-side clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Asynchronous stop-clock request, active low |
| sleep_req_n | input | 1 | Asynchronous sleep request, active low |
| core_idle | input | 1 | Core reports that it has drained and may be stopped |
| core_clk_en | output | 1 | Enable for the external core clock gate |
| pll_en | output | 1 | Enable for the PLL |
| snoop_en | output | 1 | Bus snooping permitted |
| stop_ack | output | 1 | One-cycle acknowledge on stop-grant entry |

## Verification
The main sweep resets the block and first brings it to running, stop-grant or sleep. It then applies all eight combinations of stop request, sleep request and idle, and holds them until the block settles. This separates the ignored sleep request in running, the path through stop-grant and the two exits from sleep by their settled enables. Directed sequences then count edges from a pin change to the output change, to pin down the synchronizer latency. They also hold `core_idle` low to show that gating waits for the core. Finally they count acknowledge pulses on both the entry path and the path back from sleep.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_DRAIN = 2'd1,
    PS_GRANT = 2'd2,
    PS_SLEEP = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int          STAGES    = 2,
  parameter int          WIDTH     = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm
  import pcs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic sleep_req,
  input  logic core_idle,
  output logic core_clk_en,
  output logic pll_en,
  output logic snoop_en,
  output logic stop_ack
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:   if (stop_req) state_d = core_idle ? PS_GRANT : PS_DRAIN;
      PS_DRAIN: if (!stop_req)     state_d = PS_RUN;
                else if (core_idle) state_d = PS_GRANT;
      PS_GRANT: if (!stop_req)     state_d = PS_RUN;
                else if (sleep_req) state_d = PS_SLEEP;
      PS_SLEEP: if (!sleep_req)    state_d = PS_GRANT;
      default:  state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_RUN;
      core_clk_en <= 1'b1;
      pll_en      <= 1'b1;
      snoop_en    <= 1'b1;
      stop_ack    <= 1'b0;
    end else begin
      state_q     <= state_d;
      core_clk_en <= (state_d == PS_RUN) || (state_d == PS_DRAIN);
      pll_en      <= 1'b1;
      snoop_en    <= (state_d != PS_SLEEP);
      stop_ack    <= (state_d == PS_GRANT) &&
                     ((state_q == PS_RUN) || (state_q == PS_DRAIN));
    end
  end

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    stop_ack |=> !stop_ack);
  p_ack_in_grant_r5: assert property (@(posedge clk) disable iff (rst)
    stop_ack |-> (!core_clk_en && snoop_en));
  p_idle_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && !core_idle) |=> core_clk_en);
  p_sleep_from_grant_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(snoop_en) |-> $past(!core_clk_en));
  p_wake_to_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(snoop_en) |-> !core_clk_en);
  p_sleep_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && !stop_req) |=> (core_clk_en && snoop_en));
  p_pll_kept_r10: assert property (@(posedge clk) disable iff (rst)
    pll_en);
endmodule

// File: rtl/pcs_clkstop_ctrl.sv
module pcs_clkstop_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_req_n,
  input  logic sleep_req_n,
  input  logic core_idle,
  output logic core_clk_en,
  output logic pll_en,
  output logic snoop_en,
  output logic stop_ack
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] req_n_sync;

  pcs_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (NREQ),
    .RST_VAL({NREQ{1'b1}})
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async({sleep_req_n, stop_req_n}),
    .q_sync (req_n_sync)
  );

  pcs_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stop_req   (!req_n_sync[0]),
    .sleep_req  (!req_n_sync[1]),
    .core_idle  (core_idle),
    .core_clk_en(core_clk_en),
    .pll_en     (pll_en),
    .snoop_en   (snoop_en),
    .stop_ack   (stop_ack)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (core_clk_en && pll_en && snoop_en && !stop_ack));
endmodule

// File: tb/test_pcs_clkstop_ctrl.sv
module test_pcs_clkstop_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req_n = 1'b1;
  logic sleep_req_n = 1'b1;
  logic core_idle = 1'b0;
  logic core_clk_en, pll_en, snoop_en, stop_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcs_clkstop_ctrl i_pcs_clkstop_ctrl (
    .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
    .core_idle(core_idle), .core_clk_en(core_clk_en), .pll_en(pll_en),
    .snoop_en(snoop_en), .stop_ack(stop_ack)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic stop_a, input logic sleep_a, input logic idle);
    @(negedge clk);
    stop_req_n  = !stop_a;
    sleep_req_n = !sleep_a;
    core_idle   = idle;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {clk_en,pll,snoop,ack} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {core_clk_en, pll_en, snoop_en, stop_ack};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stop_req_n = 1'b1; sleep_req_n = 1'b1; core_idle = 1'b0;
    tick(3);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // settled {clk_en,snoop} from start state (0 run,1 grant,2 sleep) and inputs
  function automatic logic [1:0] settle(input int st, input logic s, input logic sl, input logic id);
    int f;
    f = st;
    if (st == 0) f = !s ? 0 : (id ? (sl ? 2 : 1) : 3);
    if (st == 1) f = !s ? 0 : (sl ? 2 : 1);
    if (st == 2) f = sl ? 2 : (s ? 1 : 0);
    case (f)
      0, 3:    return 2'b11;
      1:       return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    int acks;
    // R1 reset state
    tick(2);
    chk("R1", outs(), 4'b1110);
    do_reset();
    tick(1);
    chk("R1", outs(), 4'b1110);

    // R2 latency, R4 ack pulse, R5 stop-grant
    drive(1, 0, 1);
    tick(2);
    chk("R2", outs(), 4'b1110);
    tick(1);
    chk("R2", outs(), 4'b0111);
    tick(1);
    chk("R4", outs(), 4'b0110);
    chk("R5", outs(), 4'b0110);

    // R7 sleep, R10 pll in sleep
    drive(1, 1, 1);
    tick(4);
    chk("R7", outs(), 4'b0100);
    chk("R10", {3'b000, pll_en}, 4'b0001);

    // R9 and R4: leave sleep, no ack
    drive(1, 0, 1);
    acks = 0;
    for (int i = 0; i < 8; i++) begin tick(1); acks += stop_ack; end
    chk("R9", outs(), 4'b0110);
    chk("R4", 4'(acks), 4'd0);

    // R6 release from stop-grant
    drive(0, 0, 1);
    tick(4);
    chk("R6", outs(), 4'b1110);

    // R3 idle wait
    drive(1, 0, 0);
    tick(8);
    chk("R3", outs(), 4'b1110);
    drive(1, 0, 1);
    tick(1);
    chk("R3", outs(), 4'b0111);

    // R6 release during idle wait
    do_reset();
    drive(1, 0, 0);
    tick(6);
    drive(0, 0, 0);
    tick(4);
    chk("R6", outs(), 4'b1110);

    // R8 sleep while running
    drive(0, 1, 1);
    tick(6);
    chk("R8", outs(), 4'b1110);

    // R9 both released in sleep: passes stop-grant, then running
    do_reset();
    drive(1, 0, 1); tick(5);
    drive(1, 1, 1); tick(5);
    drive(0, 0, 1);
    tick(3);
    chk("R9", outs(), 4'b0110);
    tick(1);
    chk("R9", outs(), 4'b1110);

    // sweep: start state x input combination (R5 R6 R7 R8 R9 R10)
    for (int st = 0; st < 3; st++) begin
      for (int c = 0; c < 8; c++) begin
        logic [1:0] e;
        do_reset();
        if (st >= 1) begin drive(1, 0, 1); tick(5); end
        if (st == 2) begin drive(1, 1, 1); tick(5); end
        drive(c[2], c[1], c[0]);
        tick(8);
        e = settle(st, c[2], c[1], c[0]);
        chk("R5_R7_R9_sweep", outs(), {e[1], 1'b1, e[0], 1'b0});
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule